// File: doc/BRIEF.md
# Multiplexed-Address Storage Array with Row Buffer

This block models a small dynamic-memory style storage array. The array is organised as rows of supercells, where each supercell is a word of several bits. It is reached through one narrow address port that carries a row number at one moment and a column number at another. A row strobe opens a row by copying all of its supercells into an internal row buffer. A later column strobe then either reads one supercell from that buffer onto the data output or overwrites it with the data input.

The buffer holds every change made while a row is open. It copies its contents back into the array when the row is closed, or when another row strobe opens a row. A column strobe that arrives while no row is open does nothing except pulse an error flag.

Row count, column count and supercell width are parameters. The address port is as wide as the wider of the row field and the column field. Row and column counts are powers of two.

Top module: `dram_mux_array`

## Requirements
- R1: After reset every supercell holds 0, `rd_data` is 0, and `rd_valid` and `cas_err` are low.
- R2: A cycle with `ras` high opens the row given by the low log2(ROWS) bits of `addr`, and copies that row into the row buffer. A read column strobe in the very next cycle already returns buffer data.
- R3: A read column strobe (`cas` high, `we` low, a row open) puts the addressed supercell on `rd_data` one clock later and pulses `rd_valid` for that one cycle. `rd_data` then holds its value until the next accepted read.
- R4: A write column strobe (`cas` and `we` high, a row open) replaces the addressed supercell in the buffer with `wr_data`. A later read of the same open row returns the new value.
- R5: A cycle with `close` high and neither strobe high writes the buffer back to the array and closes the row. Reopening that row later returns the written data.
- R6: A row strobe while a row is open first writes the open buffer back to its row, then loads the new row.
- R7: A column strobe while no row is open is ignored: no storage changes and `rd_data` is unchanged. `cas_err` is high for exactly the next cycle and `rd_valid` stays low.
- R8: A row strobe that reopens the row already open keeps the writes made to the buffer.
- R9: `ras` has priority over `cas`, and a `cas` in the same cycle is dropped without an error. `close` acts only when neither strobe is high.
- R10: During a column strobe the column number is the low log2(COLS) bits of `addr`. Each supercell is independent, so a write alters no other supercell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras | input | 1 | Row strobe: open the row on `addr` |
| cas | input | 1 | Column strobe: access the column on `addr` |
| we | input | 1 | With `cas`, write instead of read |
| close | input | 1 | Write back and close the open row |
| addr | input | AW (2) | Shared row/column address |
| wr_data | input | CELL_W (8) | Write data for a column strobe |
| rd_data | output | CELL_W (8) | Read data, held between reads |
| rd_valid | output | 1 | One-cycle pulse after an accepted read |
| cas_err | output | 1 | One-cycle pulse after a column strobe with no row open |

## Verification
The hardest state to reach from the ports is one where the row buffer holds writes that the array does not yet have, and the next event decides their fate. That event is a reopen of the same row, a switch to another row, or a close. The directed part builds each case on purpose: it writes into an open row and then applies each ending in turn, followed by reads after reopening the row. Random operations drawn from a fixed seed then mix strobes, closes and strobes with no row open, so that pending writes often meet each kind of ending.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_OPEN,
        OP_READ,
        OP_WRITE,
        OP_CLOSE,
        OP_REJECT
    } op_e;

    function automatic int unsigned field_bits(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dram_seq.sv
module dram_seq
    import dram_mux_pkg::*;
#(
    parameter int unsigned RBITS = 2,
    parameter int unsigned CBITS = 2,
    parameter int unsigned AW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras,
    input  logic             cas,
    input  logic             we,
    input  logic             close,
    input  logic [AW-1:0]    addr,
    output op_e              op,
    output logic [RBITS-1:0] row_sel,
    output logic [CBITS-1:0] col_sel,
    output logic [RBITS-1:0] cur_row,
    output logic             is_open,
    output logic             err
);

    typedef struct packed {
        logic             open;
        logic [RBITS-1:0] row;
        logic             err;
    } seq_t;

    seq_t st_d, st_q;

    assign row_sel = addr[RBITS-1:0];
    assign col_sel = addr[CBITS-1:0];

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        op       = OP_NONE;
        if (ras) begin
            op = OP_OPEN;
        end else if (cas) begin
            if (!st_q.open) op = OP_REJECT;
            else if (we)    op = OP_WRITE;
            else            op = OP_READ;
        end else if (close && st_q.open) begin
            op = OP_CLOSE;
        end
        case (op)
            OP_OPEN: begin
                st_d.open = 1'b1;
                st_d.row  = row_sel;
            end
            OP_CLOSE:  st_d.open = 1'b0;
            OP_REJECT: st_d.err  = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_row = st_q.row;
    assign is_open = st_q.open;
    assign err     = st_q.err;

    // R2: a row strobe leaves that row open
    p_open_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ras |=> (is_open && cur_row == $past(addr[RBITS-1:0])));

    // R5: a lone close leaves no row open
    p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !ras && !cas) |=> !is_open);

    // R9: a row strobe never produces an error pulse
    p_ras_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ras |=> !err);

endmodule

// File: rtl/dram_store.sv
module dram_store #(
    parameter int unsigned ROWS  = 4,
    parameter int unsigned ROW_W = 32,
    parameter int unsigned RBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_en,
    input  logic [RBITS-1:0] wb_row,
    input  logic [ROW_W-1:0] wb_data,
    input  logic [RBITS-1:0] rd_row,
    output logic [ROW_W-1:0] rd_data
);

    logic [ROWS-1:0][ROW_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wb_en) mem_d[wb_row] = wb_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_row];

    // R5/R6: a write-back lands in the array at the next edge
    p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (mem_q[$past(wb_row)] == $past(wb_data)));

endmodule

// File: rtl/dram_rowbuf.sv
module dram_rowbuf #(
    parameter int unsigned COLS   = 4,
    parameter int unsigned CELL_W = 8,
    parameter int unsigned CBITS  = 2,
    localparam int unsigned ROW_W = COLS * CELL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ROW_W-1:0]  load_data,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CBITS-1:0]  col,
    input  logic [CELL_W-1:0] wdata,
    output logic [ROW_W-1:0]  cells,
    output logic [CELL_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [COLS-1:0][CELL_W-1:0] cells;
        logic [CELL_W-1:0]           rdata;
        logic                        rvalid;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        if (load_en) begin
            st_d.cells = load_data;
        end else if (wr_en) begin
            st_d.cells[col] = wdata;
        end
        if (rd_en) begin
            st_d.rdata  = st_q.cells[col];
            st_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cells  = st_q.cells;
    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

    // R2: a load replaces the whole buffer
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cells == $past(load_data)));

    // R3: read data only moves together with a valid pulse
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == $past(rdata)));

endmodule

// File: rtl/dram_mux_array.sv
module dram_mux_array
    import dram_mux_pkg::*;
#(
    parameter int unsigned ROWS   = 4,
    parameter int unsigned COLS   = 4,
    parameter int unsigned CELL_W = 8,
    localparam int unsigned RBITS = field_bits(ROWS),
    localparam int unsigned CBITS = field_bits(COLS),
    localparam int unsigned AW    = (RBITS > CBITS) ? RBITS : CBITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras,
    input  logic              cas,
    input  logic              we,
    input  logic              close,
    input  logic [AW-1:0]     addr,
    input  logic [CELL_W-1:0] wr_data,
    output logic [CELL_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              cas_err
);

    localparam int unsigned ROW_W = COLS * CELL_W;

    op_e              op;
    logic [RBITS-1:0] row_sel, cur_row;
    logic [CBITS-1:0] col_sel;
    logic             is_open;
    logic [ROW_W-1:0] buf_cells, store_row, load_data;
    logic             wb_en, same_row;

    dram_seq #(.RBITS(RBITS), .CBITS(CBITS), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .we(we),
        .close(close), .addr(addr), .op(op), .row_sel(row_sel),
        .col_sel(col_sel), .cur_row(cur_row), .is_open(is_open),
        .err(cas_err)
    );

    assign wb_en     = (op == OP_CLOSE) || (op == OP_OPEN && is_open);
    assign same_row  = is_open && (cur_row == row_sel);
    assign load_data = same_row ? buf_cells : store_row;

    dram_store #(.ROWS(ROWS), .ROW_W(ROW_W), .RBITS(RBITS)) u_store (
        .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_row(cur_row),
        .wb_data(buf_cells), .rd_row(row_sel), .rd_data(store_row)
    );

    dram_rowbuf #(.COLS(COLS), .CELL_W(CELL_W), .CBITS(CBITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_en(op == OP_OPEN),
        .load_data(load_data), .wr_en(op == OP_WRITE),
        .rd_en(op == OP_READ), .col(col_sel), .wdata(wr_data),
        .cells(buf_cells), .rdata(rd_data), .rvalid(rd_valid)
    );

    // R7: an error pulse and a read result never share a cycle
    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cas_err && rd_valid));

    // R7: a column strobe with no open row yields no read result
    p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cas && !ras && !is_open) |=> (cas_err && !rd_valid));

    // R3: a read result follows an accepted read strobe
    p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cas && !ras && !we && is_open) |=> rd_valid);

endmodule

// File: tb/tb_dram_mux_array.sv
module tb_dram_mux_array;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int W    = 8;
    localparam int AW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras = 0, cas = 0, we = 0, close = 0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid, cas_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] m_mem [ROWS][COLS];
    logic [W-1:0] m_buf [COLS];
    bit           m_open;
    int           m_row;
    logic [W-1:0] e_rdata;
    bit           e_rvalid, e_err;

    always #5 clk = ~clk;

    dram_mux_array dut (
        .clk(clk), .rst_n(rst_n), .ras(ras), .cas(cas), .we(we),
        .close(close), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .cas_err(cas_err)
    );

    function automatic logic [W-1:0] exp_cell(int col);
        return m_buf[col];
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model(bit rs, bit cs, bit w, bit cl, int a, logic [W-1:0] d);
        e_rvalid = 0;
        e_err    = 0;
        if (rs) begin
            if (m_open) for (int c = 0; c < COLS; c++) m_mem[m_row][c] = m_buf[c];
            if (!(m_open && m_row == a))
                for (int c = 0; c < COLS; c++) m_buf[c] = m_mem[a][c];
            m_open = 1;
            m_row  = a;
        end else if (cs) begin
            if (!m_open) e_err = 1;
            else if (w) m_buf[a] = d;
            else begin
                e_rdata  = exp_cell(a);
                e_rvalid = 1;
            end
        end else if (cl && m_open) begin
            for (int c = 0; c < COLS; c++) m_mem[m_row][c] = m_buf[c];
            m_open = 0;
        end
    endtask

    task automatic step(string tag, bit rs, bit cs, bit w, bit cl, int a, logic [W-1:0] d);
        ras = rs; cas = cs; we = w; close = cl;
        addr = AW'(a); wr_data = d;
        @(negedge clk);
        ras = 0; cas = 0; we = 0; close = 0;
        model(rs, cs, w, cl, a, d);
        check(tag, "rd_data", rd_data, e_rdata);
        check(tag, "rd_valid", rd_valid, e_rvalid);
        check(tag, "cas_err", cas_err, e_err);
    endtask

    task automatic idle(string tag);     step(tag, 0, 0, 0, 0, 0, 0); endtask
    task automatic act(string tag, int r); step(tag, 1, 0, 0, 0, r, 0); endtask
    task automatic rd(string tag, int c);  step(tag, 0, 1, 0, 0, c, 0); endtask
    task automatic wr(string tag, int c, logic [W-1:0] d); step(tag, 0, 1, 1, 0, c, d); endtask
    task automatic cls(string tag);      step(tag, 0, 0, 0, 1, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) m_mem[r][c] = '0;
        for (int c = 0; c < COLS; c++) m_buf[c] = '0;
        m_open = 0; m_row = 0; e_rdata = '0; e_rvalid = 0; e_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check("R1", "rd_data", rd_data, 0);
        check("R1", "rd_valid", rd_valid, 0);
        check("R1", "cas_err", cas_err, 0);
        // R7: column strobes with no row open, including a write
        rd("R7", 1);
        wr("R7", 2, 8'hEE);
        idle("R7");
        // R1: every supercell reads zero
        for (int r = 0; r < ROWS; r++) begin
            act("R1", r);
            for (int c = 0; c < COLS; c++) rd("R1", c);
        end
        cls("R1");
        // R10: fill each supercell with a distinct value
        for (int r = 0; r < ROWS; r++) begin
            act("R10", r);
            for (int c = 0; c < COLS; c++) wr("R10", c, 8'(r * 16 + c + 1));
            cls("R10");
        end
        for (int r = 0; r < ROWS; r++) begin
            act("R10", r);
            for (int c = 0; c < COLS; c++) rd("R10", c);
        end
        // R2: read right after the row strobe
        act("R2", 2);
        rd("R2", 1);
        // R3: data held, valid low while idle
        idle("R3");
        idle("R3");
        // R4: write then read in the same open row
        wr("R4", 1, 8'hA5);
        rd("R4", 1);
        // R6: switching rows writes the buffer back
        act("R6", 0);
        act("R6", 2);
        rd("R6", 1);
        // R5: close writes back
        wr("R5", 3, 8'h3C);
        cls("R5");
        rd("R7", 3);
        act("R5", 2);
        rd("R5", 3);
        // R8: reopening the open row keeps pending writes
        wr("R8", 0, 8'h77);
        act("R8", 2);
        rd("R8", 0);
        // R9: priorities
        step("R9", 1, 1, 1, 0, 1, 8'h55);
        rd("R9", 1);
        step("R9", 0, 1, 0, 1, 2, 0);
        rd("R9", 0);
        step("R9", 1, 0, 0, 1, 3, 0);
        rd("R9", 0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned k = $urandom % 8;
            int unsigned a = $urandom % 4;
            logic [W-1:0] d = 8'($urandom);
            case (k)
                0:       act("R6", int'(a));
                1, 2:    wr("R4", int'(a), d);
                3, 4:    rd("R3", int'(a));
                5:       cls("R5");
                6:       step("R9", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), int'(a), d);
                default: idle("R3");
            endcase
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule